// File: doc/BRIEF.md
# Parallel PRBS Word Generator

This block produces a pseudo-random binary sequence one word at a time. A linear feedback shift register is held in a state register. On each clock where the step enable is high, the register moves forward by DATA_W single-bit steps in one cycle. The DATA_W bits made on the way are packed into a registered output word.

Parameters fix the register length, the feedback polynomial, the seed and the feedback form (Fibonacci or Galois). Two more parameters control whether the word is mirrored and whether it is complemented. With a 31-bit register, polynomial 0x10000001 and inversion on, the block emits the common PRBS31 pattern. With a 9-bit register and polynomial 0x021, it emits PRBS9. Typical uses are link test pattern sources and scramblers with a fixed polynomial.

Top module: `prbs_word_gen`

## Requirements
- R1: Reset is synchronous and active high. While it is asserted, the state register loads SEED (all ones by default) and the output word clears to zero. The step enable has no effect during reset.
- R2: In Fibonacci form, one step shifts the state left by one and drops the old top bit. The new bit 0 is the feedback bit: the XOR of state bit STATE_W-1 and of state bit i-1 for every i >= 1 where POLY bit i is set. That feedback bit is the bit generated by the step. The state never becomes all zero.
- R3: Each clock with the step enable high and reset low advances the state by exactly DATA_W steps. The word seen after the first enabled clock following reset holds the first DATA_W bits generated from SEED. It does not hold the seed itself.
- R4: The first bit generated in a clock lands in word bit DATA_W-1 and the last in bit 0. As a result, the earliest byte of a multi-byte word sits in the top lane, and each byte carries its earliest bit in its bit 7.
- R5: With INVERT set, every word bit is the complement of the generated bit. With INVERT clear, the bit is passed as generated.
- R6: While the step enable is low and reset is low, both the state and the output word hold their values. Raising the enable again continues the sequence where it stopped.
- R7: With REVERSE set, the whole output word is mirrored: the bit that R4 places at position k appears at position DATA_W-1-k.
- R8: In Galois form, the generated bit is state bit STATE_W-1 before the step. The state shifts left by one with a zero in bit 0. When the generated bit is one, the shifted state is then XORed with POLY.
- R9: The PRBS9 setting (9 bits, POLY 0x021, taps at state bits 8 and 4) and the PRBS31 setting (31 bits, POLY 0x10000001, taps at state bits 30 and 27) both give the correct sequence at output widths of 8 and 64 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Advance by one word on this clock |
| word_o | output | DATA_W | Registered sequence word |

## Verification
The assertions assume that reset is high from time zero and through the first clock edge. They also assume that SEED is not all zero, because an all-zero Fibonacci or Galois state never leaves zero and the nonzero-state property would then fail. The bench holds reset from the first instant, uses only the all-ones default seed, and changes the enable and reset only on falling clock edges. Outputs are sampled on falling edges as well, so every rising edge sees stable inputs.

// File: rtl/prbs_pkg.sv
package prbs_pkg;

  typedef enum logic {
    FORM_FIB    = 1'b0,
    FORM_GALOIS = 1'b1
  } prbs_form_e;

endpackage

// File: rtl/prbs_advance.sv
// Unrolled next-state function: DATA_W single steps in one combinational pass.
module prbs_advance #(
  parameter int                      STATE_W = 31,
  parameter logic [STATE_W-1:0]      POLY    = 31'h10000001,
  parameter prbs_pkg::prbs_form_e    FORM    = prbs_pkg::FORM_FIB,
  parameter int                      DATA_W  = 8
) (
  input  logic [STATE_W-1:0] state_i,
  output logic [STATE_W-1:0] state_o,
  output logic [DATA_W-1:0]  bits_o
);

  logic [STATE_W-1:0] chain [DATA_W+1];

  assign chain[0] = state_i;
  assign state_o  = chain[DATA_W];

  for (genvar k = 0; k < DATA_W; k++) begin : g_step
    if (FORM == prbs_pkg::FORM_GALOIS) begin : g_gal
      logic top_bit;
      assign top_bit = chain[k][STATE_W-1];
      assign chain[k+1] = {chain[k][STATE_W-2:0], 1'b0} ^ (top_bit ? POLY : '0);
      assign bits_o[DATA_W-1-k] = top_bit;
    end else begin : g_fib
      // poly bit 0 pairs with the top state bit, poly bit i with state bit i-1
      localparam logic [STATE_W-1:0] TAP_MASK = {POLY[0], POLY[STATE_W-1:1]};
      logic fb;
      assign fb = ^(chain[k] & TAP_MASK);
      assign chain[k+1] = {chain[k][STATE_W-2:0], fb};
      assign bits_o[DATA_W-1-k] = fb;
    end
  end

endmodule

// File: rtl/prbs_word_fmt.sv
// Output shaping: optional mirror of the word, optional complement.
module prbs_word_fmt #(
  parameter int   DATA_W  = 8,
  parameter logic REVERSE = 1'b0,
  parameter logic INVERT  = 1'b1
) (
  input  logic [DATA_W-1:0] bits_i,
  output logic [DATA_W-1:0] word_o
);

  logic [DATA_W-1:0] ordered;

  if (REVERSE) begin : g_rev
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      assign ordered[b] = bits_i[DATA_W-1-b];
    end
  end else begin : g_fwd
    assign ordered = bits_i;
  end

  assign word_o = ordered ^ {DATA_W{INVERT}};

endmodule

// File: rtl/prbs_word_gen.sv
module prbs_word_gen #(
  parameter int                      STATE_W = 31,
  parameter logic [STATE_W-1:0]      POLY    = 31'h10000001,
  parameter logic [STATE_W-1:0]      SEED    = '1,
  parameter prbs_pkg::prbs_form_e    FORM    = prbs_pkg::FORM_FIB,
  parameter logic                    REVERSE = 1'b0,
  parameter logic                    INVERT  = 1'b1,
  parameter int                      DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_en,
  output logic [DATA_W-1:0] word_o
);

  logic [STATE_W-1:0] state_q;
  logic [STATE_W-1:0] state_nxt;
  logic [DATA_W-1:0]  raw_bits;
  logic [DATA_W-1:0]  word_nxt;
  logic [DATA_W-1:0]  word_q;

  prbs_advance #(
    .STATE_W (STATE_W),
    .POLY    (POLY),
    .FORM    (FORM),
    .DATA_W  (DATA_W)
  ) u_adv (
    .state_i (state_q),
    .state_o (state_nxt),
    .bits_o  (raw_bits)
  );

  prbs_word_fmt #(
    .DATA_W  (DATA_W),
    .REVERSE (REVERSE),
    .INVERT  (INVERT)
  ) u_fmt (
    .bits_i (raw_bits),
    .word_o (word_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEED;
      word_q  <= '0;
    end else if (step_en) begin
      state_q <= state_nxt;
      word_q  <= word_nxt;
    end
  end

  assign word_o = word_q;

endmodule

// File: rtl/prbs_word_gen_chk.sv
module prbs_word_gen_chk #(
  parameter int                 STATE_W = 31,
  parameter int                 DATA_W  = 8,
  parameter logic [STATE_W-1:0] SEED    = '1
) (
  input logic               clk,
  input logic               rst,
  input logic               step_en,
  input logic [STATE_W-1:0] state_q,
  input logic [DATA_W-1:0]  word_q
);

  logic seen_rst;
  always_ff @(posedge clk) begin
    if (rst) seen_rst <= 1'b1;
    else if (seen_rst !== 1'b1) seen_rst <= 1'b0;
  end

  // R1: reset loads the seed and clears the word whatever the enable does
  p_seed_load_r1: assert property (@(posedge clk)
    rst |=> (state_q == SEED) && (word_q == '0));

  // R6: no enable, no movement of the state
  p_hold_state_r6: assert property (@(posedge clk) disable iff (rst)
    (seen_rst && !step_en) |=> $stable(state_q));

  // R6: no enable, no movement of the output word
  p_hold_word_r6: assert property (@(posedge clk) disable iff (rst)
    (seen_rst && !step_en) |=> $stable(word_q));

  // R2: a nonzero seed never collapses to the all-zero lock-up state
  p_state_nonzero_r2: assert property (@(posedge clk) disable iff (rst)
    seen_rst |-> (state_q != '0));

endmodule

bind prbs_word_gen prbs_word_gen_chk #(
  .STATE_W (STATE_W),
  .DATA_W  (DATA_W),
  .SEED    (SEED)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .step_en (step_en),
  .state_q (state_q),
  .word_q  (word_q)
);

// File: tb/prbs_word_gen_tb_top.sv
module prbs_word_gen_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  int   n_chk = 0;
  int   n_bad = 0;

  always #10 clk = ~clk;

  logic [7:0]  w_p31b;   // PRBS31, 8 bit, inverted
  logic [63:0] w_p9w;    // PRBS9, 64 bit, inverted
  logic [63:0] w_p31r;   // PRBS31, 64 bit, mirrored, not inverted
  logic [7:0]  w_gal;    // Galois 9 bit, 8 bit, not inverted

  prbs_word_gen #(.STATE_W(31), .POLY(31'h10000001), .FORM(prbs_pkg::FORM_FIB),
                  .REVERSE(1'b0), .INVERT(1'b1), .DATA_W(8))
    dut_i (.clk(clk), .rst(rst), .step_en(en), .word_o(w_p31b));

  prbs_word_gen #(.STATE_W(9), .POLY(9'h021), .FORM(prbs_pkg::FORM_FIB),
                  .REVERSE(1'b0), .INVERT(1'b1), .DATA_W(64))
    dut_p9w (.clk(clk), .rst(rst), .step_en(en), .word_o(w_p9w));

  prbs_word_gen #(.STATE_W(31), .POLY(31'h10000001), .FORM(prbs_pkg::FORM_FIB),
                  .REVERSE(1'b1), .INVERT(1'b0), .DATA_W(64))
    dut_p31r (.clk(clk), .rst(rst), .step_en(en), .word_o(w_p31r));

  prbs_word_gen #(.STATE_W(9), .POLY(9'h021), .FORM(prbs_pkg::FORM_GALOIS),
                  .REVERSE(1'b0), .INVERT(1'b0), .DATA_W(8))
    dut_gal (.clk(clk), .rst(rst), .step_en(en), .word_o(w_gal));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Fibonacci model with explicit tap positions; first bit lands at bit n-1
  function automatic logic [63:0] fib_word(input int w, input int ta, input int tb,
                                           ref logic [63:0] st, input int n);
    logic [63:0] r = '0;
    for (int j = 0; j < n; j++) begin
      logic fb = st[ta] ^ st[tb];
      st = ((st << 1) | 64'(fb)) & ((64'd1 << w) - 1);
      r[n-1-j] = fb;
    end
    return r;
  endfunction

  function automatic logic [63:0] gal_word(input int w, input logic [63:0] poly,
                                           ref logic [63:0] st, input int n);
    logic [63:0] r = '0;
    for (int j = 0; j < n; j++) begin
      logic top = st[w-1];
      st = (st << 1) & ((64'd1 << w) - 1);
      if (top) st = st ^ poly;
      r[n-1-j] = top;
    end
    return r;
  endfunction

  function automatic logic [63:0] mirror(input logic [63:0] v, input int n);
    logic [63:0] r = '0;
    for (int j = 0; j < n; j++) r[n-1-j] = v[j];
    return r;
  endfunction

  function automatic logic [63:0] inv(input logic [63:0] v, input int n);
    return ~v & ((n == 64) ? '1 : ((64'd1 << n) - 1));
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    en  = 1'b1;                 // must be ignored during reset
    repeat (3) @(negedge clk);
    rst = 1'b0;
    en  = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 word zero after reset", 64'(w_p31b), 64'h0);
    check("R1 wide word zero after reset", w_p9w, 64'h0);
    repeat (3) @(negedge clk);
    check("R6 idle after reset keeps zero", 64'(w_p31b), 64'h0);
    check("R6 idle after reset keeps zero (gal)", 64'(w_gal), 64'h0);
  endtask

  task automatic t_prbs31_byte();
    logic [63:0] st = 64'h7FFF_FFFF;
    do_reset();
    en = 1'b1;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      check(i == 0 ? "R3 first word follows seed" : "R2 R4 R5 R9 prbs31 byte",
            64'(w_p31b), inv(fib_word(31, 30, 27, st, 8), 8));
    end
    en = 1'b0;
  endtask

  task automatic t_hold();
    logic [63:0] st = 64'h7FFF_FFFF;
    logic [63:0] held;
    do_reset();
    en = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      held = inv(fib_word(31, 30, 27, st, 8), 8);
      check("R3 prbs31 word before pause", 64'(w_p31b), held);
    end
    en = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R6 word held with enable low", 64'(w_p31b), held);
    end
    en = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R6 sequence resumes after pause", 64'(w_p31b), inv(fib_word(31, 30, 27, st, 8), 8));
    end
    en = 1'b0;
  endtask

  task automatic t_prbs9_wide();
    logic [63:0] st = 64'h1FF;
    do_reset();
    en = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      check("R4 R9 prbs9 64-bit lanes", w_p9w, inv(fib_word(9, 8, 4, st, 64), 64));
    end
    en = 1'b0;
  endtask

  task automatic t_reverse();
    logic [63:0] st = 64'h7FFF_FFFF;
    do_reset();
    en = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      check("R7 R5 mirrored uninverted prbs31", w_p31r, mirror(fib_word(31, 30, 27, st, 64), 64));
    end
    en = 1'b0;
  endtask

  task automatic t_galois();
    logic [63:0] st = 64'h1FF;
    do_reset();
    en = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      check("R8 galois step", 64'(w_gal), gal_word(9, 64'h021, st, 8));
    end
    en = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_prbs31_byte();
    t_hold();
    t_prbs9_wide();
    t_reverse();
    t_galois();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule